// File: doc/BRIEF.md
# Boot and Controller Clock Sequencer

This block decides when the embedded controller may run after a reset and which oscillator clocks it. A low level on the reset pin or a high level on the power-on-reset pulse puts the whole sequencer into reset. Reset assertion takes effect at once, and its release passes through a two-stage synchronizer. Once reset releases, the block counts a fixed number of main-crystal cycles (50 ms at 16.9344 MHz by default). When that count completes, it raises the CPU run enable and a one-cycle program-start pulse that loads fetch address zero. The disc signal-processing section is kept in standby throughout.

The main crystal is always the source after reset, and the shared alternate-oscillator pins stay in port mode. Software can then request a 75 kHz crystal, a 32.768 kHz crystal or an RC oscillator. The request turns that oscillator on, but the clock mux moves to it only after a settle count has run out. A clock-stop command halts the CPU and turns off the alternate oscillator. A pin-change request from a port whose wake enable is set resumes operation. If the selected source is an alternate oscillator, the block first restarts it and waits out its settle time again.

Top module: `bootclk_seq`

## Requirements
- R1: While `rst_pin_n` is low, `cpu_run`=0, `prog_start`=0, `clk_sel`=0 (main crystal) and `osc_en`=0 (all shared pins in port mode).
- R2: After reset releases, `cpu_run` rises on exactly the (STANDBY_CYCLES+2)-th rising clock edge, which covers two synchronizer stages plus the standby count.
- R3: `prog_start` is high for exactly one cycle, in the cycle where `cpu_run` first rises after a reset, and it always coincides with `cpu_run`.
- R4: `sp_standby` is 1 at all times after reset, including when the program starts.
- R5: Source encoding on `sel_src`/`clk_sel` is 0=main, 1=75 kHz, 2=32.768 kHz, 3=RC, and `osc_en` bit 0/1/2 enables 75 kHz/32.768 kHz/RC. A running write of an alternate source sets its single `osc_en` bit on the write edge, and `clk_sel` takes the new code exactly SETTLE_CYCLES edges later.
- R6: A running write of source 0 sets `clk_sel`=0 and `osc_en`=0 on the next edge and cancels any pending switch.
- R7: Writing a different alternate source while clocked from an alternate source returns `clk_sel` to 0 on the write edge. The new source is applied after its own full settle count.
- R8: Select writes and clock-stop commands have no effect while `cpu_run` is 0.
- R9: A clock-stop while running drops `cpu_run` and clears `osc_en` on the next edge and leaves `clk_sel` unchanged.
- R10: While stopped, a `wake_req` bit whose matching `wake_en` bit is 0 has no effect.
- R11: An enabled wake with `clk_sel`=0 raises `cpu_run` on the next edge. With an alternate source, the wake re-enables that oscillator on the next edge and raises `cpu_run` SETTLE_CYCLES edges after that, with no `prog_start`.
- R12: A `por_pulse` has the same effect as the reset pin: it resets immediately and then repeats the full standby count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main-crystal clock |
| rst_pin_n | input | 1 | Active-low reset pin |
| por_pulse | input | 1 | Power-on-reset pulse, active high |
| sel_wr | input | 1 | Clock-select write strobe |
| sel_src | input | 2 | Requested controller clock source |
| ckstp | input | 1 | Clock-stop command strobe |
| wake_req | input | NUM_PORTS | Per-port pin-change request |
| wake_en | input | NUM_PORTS | Per-port wake enable |
| cpu_run | output | 1 | CPU run enable |
| prog_start | output | 1 | One-cycle pulse forcing fetch address zero |
| sp_standby | output | 1 | Holds the signal-processing section in standby |
| clk_sel | output | 2 | Controller clock mux select |
| osc_en | output | 3 | Alternate oscillator enables (one-hot or zero) |

## Verification
The bench targets exact edge counts. A design with one synchronizer stage too few or too many, or a standby or settle counter that is off by one, moves `cpu_run` or `clk_sel` by one cycle and fails the exact-count checks. The bench also tries switches that would put the mux on an unsettled oscillator: a switch from one alternate source to another, and a wake into an alternate source. A design that skips the settle count there switches early. The remaining checks cover stimulus that must be ignored: writes during the standby count, a stop while already stopped, masked wake requests, and a main-source write that must cancel a pending switch. A design that leaks any of these shows a changed `clk_sel`, `osc_en` or `cpu_run`.

// File: rtl/bootclk_pkg.sv
package bootclk_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_XT75 = 2'd1,
    SRC_XT32 = 2'd2,
    SRC_RC   = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_RUN  = 2'd1,
    ST_STOP = 2'd2,
    ST_WAKE = 2'd3
  } seq_state_e;

  localparam int unsigned NUM_ALT = 3;

  function automatic logic [NUM_ALT-1:0] alt_onehot(input clk_src_e src);
    logic [NUM_ALT-1:0] v;
    v = '0;
    if (src != SRC_MAIN) v[src - 2'd1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/bootclk_rst_sync.sv
module bootclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bootclk_counter.sv
module bootclk_counter #(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned W = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_end;

  assign at_end = (cnt_q == W'(LIMIT - 1));
  assign done   = en && !clr && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (en) begin
      if (at_end)    cnt_d = '0;
      else           cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bootclk_wake.sv
module bootclk_wake #(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0] req,
  input  logic [NUM_PORTS-1:0] en,
  output logic                 hit
);
  logic [NUM_PORTS-1:0] gated;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign gated[p] = req[p] & en[p];
  end

  assign hit = |gated;
endmodule

// File: rtl/bootclk_seq.sv
module bootclk_seq
  import bootclk_pkg::*;
#(
  parameter int unsigned STANDBY_CYCLES = 846720,
  parameter int unsigned SETTLE_CYCLES  = 4096,
  parameter int unsigned NUM_PORTS      = 4,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst_pin_n,
  input  logic                 por_pulse,
  input  logic                 sel_wr,
  input  logic [1:0]           sel_src,
  input  logic                 ckstp,
  input  logic [NUM_PORTS-1:0] wake_req,
  input  logic [NUM_PORTS-1:0] wake_en,
  output logic                 cpu_run,
  output logic                 prog_start,
  output logic                 sp_standby,
  output logic [1:0]           clk_sel,
  output logic [NUM_ALT-1:0]   osc_en
);
  logic arst_n, srst_n;
  logic boot_done, settle_done, settle_clr, wake_hit;

  seq_state_e         state_q, state_d;
  clk_src_e           cur_q, cur_d, pend_q, pend_d;
  logic [NUM_ALT-1:0] osc_q, osc_d;
  logic               settle_q, settle_d;
  logic               start_q, start_d;
  clk_src_e           req_src;

  assign arst_n  = rst_pin_n & ~por_pulse;
  assign req_src = clk_src_e'(sel_src);

  bootclk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(arst_n), .srst_n(srst_n)
  );

  bootclk_counter #(.LIMIT(STANDBY_CYCLES)) u_boot_cnt (
    .clk(clk), .rst_n(srst_n), .clr(1'b0),
    .en(state_q == ST_BOOT), .done(boot_done)
  );

  bootclk_counter #(.LIMIT(SETTLE_CYCLES)) u_settle_cnt (
    .clk(clk), .rst_n(srst_n), .clr(settle_clr),
    .en(settle_q), .done(settle_done)
  );

  bootclk_wake #(.NUM_PORTS(NUM_PORTS)) u_wake (
    .req(wake_req), .en(wake_en), .hit(wake_hit)
  );

  always_comb begin
    state_d    = state_q;
    cur_d      = cur_q;
    pend_d     = pend_q;
    osc_d      = osc_q;
    settle_d   = settle_q;
    start_d    = 1'b0;
    settle_clr = 1'b0;
    unique case (state_q)
      ST_BOOT: begin
        if (boot_done) begin
          state_d = ST_RUN;
          start_d = 1'b1;
        end
      end
      ST_RUN: begin
        if (ckstp) begin
          state_d  = ST_STOP;
          osc_d    = '0;
          settle_d = 1'b0;
        end else begin
          if (settle_q && settle_done) begin
            cur_d    = pend_q;
            settle_d = 1'b0;
          end
          if (sel_wr) begin
            if (req_src == SRC_MAIN) begin
              cur_d    = SRC_MAIN;
              osc_d    = '0;
              settle_d = 1'b0;
            end else if (req_src != cur_q || settle_q) begin
              cur_d      = SRC_MAIN;
              pend_d     = req_src;
              osc_d      = alt_onehot(req_src);
              settle_d   = 1'b1;
              settle_clr = 1'b1;
            end
          end
        end
      end
      ST_STOP: begin
        if (wake_hit) begin
          if (cur_q == SRC_MAIN) begin
            state_d = ST_RUN;
          end else begin
            state_d    = ST_WAKE;
            osc_d      = alt_onehot(cur_q);
            settle_d   = 1'b1;
            settle_clr = 1'b1;
          end
        end
      end
      ST_WAKE: begin
        if (settle_done) begin
          state_d  = ST_RUN;
          settle_d = 1'b0;
        end
      end
      default: state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q  <= ST_BOOT;
      cur_q    <= SRC_MAIN;
      pend_q   <= SRC_MAIN;
      osc_q    <= '0;
      settle_q <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      cur_q    <= cur_d;
      pend_q   <= pend_d;
      osc_q    <= osc_d;
      settle_q <= settle_d;
      start_q  <= start_d;
    end
  end

  assign cpu_run    = (state_q == ST_RUN);
  assign prog_start = start_q;
  assign sp_standby = 1'b1;
  assign clk_sel    = cur_q;
  assign osc_en     = osc_q;
endmodule

// File: rtl/bootclk_seq_chk.sv
module bootclk_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_run,
  input logic       prog_start,
  input logic       sp_standby,
  input logic       sel_wr,
  input logic       ckstp,
  input logic [1:0] clk_sel,
  input logic [2:0] osc_en
);
  // R3
  start_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> cpu_run);

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

  // R4
  dsp_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_standby);

  // R5
  osc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(osc_en));

  // R5
  alt_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_run && clk_sel != 2'd0) |-> (osc_en != 3'd0));

  // R8
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_run && sel_wr) |=> $stable(clk_sel));

  // R9
  stop_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_run && ckstp) |=> (!cpu_run && osc_en == 3'd0 && $stable(clk_sel)));
endmodule

bind bootclk_seq bootclk_seq_chk u_chk (
  .clk(clk), .rst_n(srst_n), .cpu_run(cpu_run), .prog_start(prog_start),
  .sp_standby(sp_standby), .sel_wr(sel_wr), .ckstp(ckstp),
  .clk_sel(clk_sel), .osc_en(osc_en)
);

// File: tb/tb_bootclk_seq.sv
module tb_bootclk_seq;
  localparam int STBY = 40;
  localparam int SETL = 12;
  localparam int NP   = 4;

  logic clk = 1'b0;
  logic rst_pin_n, por_pulse, sel_wr, ckstp;
  logic [1:0] sel_src;
  logic [NP-1:0] wake_req, wake_en;
  logic cpu_run, prog_start, sp_standby;
  logic [1:0] clk_sel;
  logic [2:0] osc_en;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bootclk_seq #(.STANDBY_CYCLES(STBY), .SETTLE_CYCLES(SETL), .NUM_PORTS(NP)) dut (
    .clk(clk), .rst_pin_n(rst_pin_n), .por_pulse(por_pulse), .sel_wr(sel_wr),
    .sel_src(sel_src), .ckstp(ckstp), .wake_req(wake_req), .wake_en(wake_en),
    .cpu_run(cpu_run), .prog_start(prog_start), .sp_standby(sp_standby),
    .clk_sel(clk_sel), .osc_en(osc_en)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_src(input logic [1:0] s);
    sel_wr = 1'b1; sel_src = s;
    step(1);
    sel_wr = 1'b0;
  endtask

  // counts edges since reset release until cpu_run rises; R2 R3 R4
  task automatic boot_wait(input int already, input string tag);
    int cnt;
    cnt = already;
    while (!cpu_run && cnt < 1000) begin
      step(1);
      cnt++;
    end
    check({tag, " R2 run edge"}, cnt, STBY + 2);
    check({tag, " R3 start with run"}, int'(prog_start), 1);
    check({tag, " R4 standby at start"}, int'(sp_standby), 1);
    step(1);
    check({tag, " R3 start one cycle"}, int'(prog_start), 0);
    check({tag, " R2 stays running"}, int'(cpu_run), 1);
  endtask

  task automatic t_reset_boot;
    rst_pin_n = 1'b0;
    step(3);
    check("R1 cpu_run", int'(cpu_run), 0);
    check("R1 prog_start", int'(prog_start), 0);
    check("R1 clk_sel", int'(clk_sel), 0);
    check("R1 osc_en", int'(osc_en), 0);
    check("R4 standby in reset", int'(sp_standby), 1);
    rst_pin_n = 1'b1;
    step(5);
    // R8: writes and stop during the standby count
    sel_wr = 1'b1; sel_src = 2'd1; ckstp = 1'b1;
    step(1);
    sel_wr = 1'b0; ckstp = 1'b0;
    check("R8 boot write clk_sel", int'(clk_sel), 0);
    check("R8 boot write osc_en", int'(osc_en), 0);
    boot_wait(6, "pin");
  endtask

  task automatic t_select_alt;
    write_src(2'd2);
    check("R5 osc_en on write", int'(osc_en), 2);
    check("R5 clk_sel held", int'(clk_sel), 0);
    step(SETL - 1);
    check("R5 clk_sel before settle", int'(clk_sel), 0);
    step(1);
    check("R5 clk_sel after settle", int'(clk_sel), 2);
  endtask

  task automatic t_swap_alt;
    write_src(2'd3);
    check("R7 back to main", int'(clk_sel), 0);
    check("R7 osc_en rc", int'(osc_en), 4);
    step(SETL - 1);
    check("R7 before settle", int'(clk_sel), 0);
    step(1);
    check("R7 after settle", int'(clk_sel), 3);
  endtask

  task automatic t_main;
    write_src(2'd0);
    check("R6 clk_sel main", int'(clk_sel), 0);
    check("R6 osc_en off", int'(osc_en), 0);
    write_src(2'd1);
    step(3);
    write_src(2'd0);
    step(SETL + 2);
    check("R6 pending cancelled", int'(clk_sel), 0);
    check("R6 osc_en cancelled", int'(osc_en), 0);
  endtask

  task automatic t_stop_wake_main;
    ckstp = 1'b1;
    step(1);
    ckstp = 1'b0;
    check("R9 run dropped", int'(cpu_run), 0);
    check("R9 clk_sel kept", int'(clk_sel), 0);
    write_src(2'd1);
    check("R8 stopped write clk_sel", int'(clk_sel), 0);
    check("R8 stopped write osc_en", int'(osc_en), 0);
    wake_en = 4'b0001; wake_req = 4'b0010;
    step(1);
    wake_req = '0;
    check("R10 masked wake", int'(cpu_run), 0);
    wake_req = 4'b0001;
    step(1);
    wake_req = '0;
    check("R11 wake main", int'(cpu_run), 1);
    check("R11 no start on wake", int'(prog_start), 0);
  endtask

  task automatic t_stop_wake_alt;
    write_src(2'd1);
    step(SETL);
    check("R5 clk_sel 75k", int'(clk_sel), 1);
    ckstp = 1'b1;
    step(1);
    ckstp = 1'b0;
    check("R9 run off alt", int'(cpu_run), 0);
    check("R9 osc off", int'(osc_en), 0);
    check("R9 clk_sel kept alt", int'(clk_sel), 1);
    wake_en = 4'b1000; wake_req = 4'b1000;
    step(1);
    wake_req = '0;
    check("R11 osc restarted", int'(osc_en), 1);
    check("R11 not yet running", int'(cpu_run), 0);
    step(SETL - 1);
    check("R11 before settle", int'(cpu_run), 0);
    step(1);
    check("R11 running after settle", int'(cpu_run), 1);
    check("R11 no start pulse", int'(prog_start), 0);
  endtask

  task automatic t_por;
    por_pulse = 1'b1;
    #1;
    check("R12 run off", int'(cpu_run), 0);
    check("R12 clk_sel main", int'(clk_sel), 0);
    check("R12 osc off", int'(osc_en), 0);
    step(2);
    por_pulse = 1'b0;
    boot_wait(0, "por R12");
  endtask

  initial begin
    rst_pin_n = 1'b0; por_pulse = 1'b0; sel_wr = 1'b0; sel_src = 2'd0;
    ckstp = 1'b0; wake_req = '0; wake_en = '0;
    step(1);
    t_reset_boot();
    t_select_alt();
    t_swap_alt();
    t_main();
    t_stop_wake_main();
    t_stop_wake_alt();
    t_por();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule